// File: doc/BRIEF.md
# SDRAM Write-Burst Termination Sequencer

This block drives the command, bank, address and data-mask pins for the write path of one SDRAM bank. The bank is assumed open when a request arrives. A request names a bank, a start column and a burst kind: two beats, a fixed length, or a full page. It may also carry a nonzero stop count that ends the burst before its natural length. Each request picks one of two ways to end the write. The first is an immediate READ to a given column, which hands the bus over to a read. The second is a PRECHARGE, of this bank or of all banks, that truncates the burst.

Write data is taken from `wr_data` one cycle before each beat appears on the pins. The `dat_take` strobe marks the cycles in which the word is captured. When a burst is truncated by PRECHARGE, the sequencer holds DQM high from the cycle after the last wanted beat through the PRECHARGE cycle, so that no unwanted word is written. It spaces the PRECHARGE after the last beat by the write recovery time. It keeps `req_ready` low until the precharge time has elapsed, so a new ACTIVE or request to the bank is only offered when it is legal.

Command pins are encoded as {CS#, RAS#, CAS#, WE#}: NOP 0111, WRITE 0100, READ 0101, PRECHARGE 0010, ACTIVE 0011. A WRITE never requests auto precharge. The recovery length is set by `FAST_CLK`: two cycles for clock periods below 15 ns, one cycle otherwise. `RP_CYC` gives the precharge time in cycles.

Top module: `sdwr_term_seq`

## Requirements
- R1: After reset, and until a request is accepted, sd_cmd is NOP (0111), sd_dqm, dq_oe and dat_take are low, sd_addr, sd_ba and dq_out are zero, and req_ready is high.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both high. The cycle after that edge shows WRITE (0100), sd_ba equal to the request bank, and sd_addr holding the start column with bit AP_BIT low. dq_oe is high, and dq_out holds the wr_data present in the accept cycle. req_ready is low from that cycle on.
- R3: The burst has N beats. The natural length is 2 for kind 00, FIX_LEN for kind 01, and 2^COL_W for kinds 10 and 11. N is req_stop when req_stop is nonzero and below the natural length, and the natural length otherwise. The beats occupy N consecutive cycles starting at the WRITE, with NOP on the later ones. Each beat's dq_out is the wr_data of the preceding cycle, and dat_take is high in the cycle before each beat.
- R4: With req_pre low, READ (0101) appears in the cycle right after the last beat, with sd_ba equal to the bank and sd_addr holding req_rcol with bit AP_BIT low. From that cycle on, dq_oe is low and dq_out is zero whatever wr_data does. req_ready rises one cycle later.
- R5: With req_pre high, PRECHARGE (0010) appears WR cycles after the last beat, where WR is 2 when FAST_CLK is 1 and 1 otherwise. The cycles in between carry NOP. On the PRECHARGE cycle, sd_addr has only bit AP_BIT possibly set, equal to req_all, and sd_ba equals the bank.
- R6: When a precharge-ended burst is truncated (N below the natural length), sd_dqm is high in every cycle from the one after the last beat through the PRECHARGE cycle.
- R7: When a precharge-ended burst runs to its natural length, including a two-beat burst, sd_dqm stays low throughout.
- R8: After the PRECHARGE cycle, the next RP_CYC-1 cycles carry NOP with req_ready low. req_ready is high in the cycle RP_CYC after the PRECHARGE.
- R9: While req_ready is low, req_valid and the request fields have no effect: no WRITE is issued and the running sequence is unchanged.
- R10: sd_dqm is low during data beats and on a READ ending, and is never high while dq_oe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted; low until the bank is free again |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Start column of the write |
| req_kind | input | 2 | Burst kind: 00 two, 01 fixed, 10/11 full page |
| req_stop | input | COL_W+1 | Wanted beat count, 0 for the natural length |
| req_pre | input | 1 | 1: end with PRECHARGE, 0: end with READ |
| req_all | input | 1 | PRECHARGE targets all banks |
| req_rcol | input | COL_W | Column for the ending READ |
| wr_data | input | DATA_W | Write word for the next beat |
| dat_take | output | 1 | wr_data is captured at the coming edge |
| sd_cmd | output | 4 | {CS#, RAS#, CAS#, WE#} |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Address bus |
| sd_dqm | output | 1 | Data mask |
| dq_out | output | DATA_W | Write data to the DQ pins |
| dq_oe | output | 1 | DQ output enable |

## Verification
The bench builds the sequencer with COL_W = 4, so a full-page burst is sixteen beats and can run to its natural end within a short test. FIX_LEN is 4, so stop counts both below and above the fixed length are exercised. It uses FAST_CLK = 1, which gives two-cycle recovery and so a NOP cycle between the last beat and the PRECHARGE in which the mask must already be high. RP_CYC is 3, which leaves two gap cycles where the ready gate and the NOP stream can be seen while req_valid is held high with altered fields.

// File: rtl/sdwr_pkg.sv
package sdwr_pkg;

    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_PRE = 4'b0010
    } sd_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_WREC = 2'd2,
        ST_RP   = 2'd3
    } seq_st_e;

    localparam logic [1:0] KIND_TWO  = 2'b00;
    localparam logic [1:0] KIND_FIX  = 2'b01;

endpackage

// File: rtl/sdwr_beat_calc.sv
module sdwr_beat_calc
    import sdwr_pkg::*;
#(
    parameter int COL_W   = 10,
    parameter int FIX_LEN = 8,
    parameter int CNT_W   = COL_W + 1
) (
    input  logic [1:0]       kind_i,
    input  logic [CNT_W-1:0] stop_i,
    output logic [CNT_W-1:0] beats_o,
    output logic             trunc_o
);

    localparam int PAGE_LEN = 1 << COL_W;

    logic [CNT_W-1:0] natural_len;
    logic             cut;

    always_comb begin
        unique case (kind_i)
            KIND_TWO: natural_len = CNT_W'(2);
            KIND_FIX: natural_len = CNT_W'(FIX_LEN);
            default:  natural_len = CNT_W'(PAGE_LEN);
        endcase
        cut     = (stop_i != '0) && (stop_i < natural_len);
        beats_o = cut ? stop_i : natural_len;
        trunc_o = cut;
    end

endmodule

// File: rtl/sdwr_addr_fmt.sv
module sdwr_addr_fmt #(
    parameter int COL_W  = 10,
    parameter int ADDR_W = 13,
    parameter int AP_BIT = 10
) (
    input  logic [COL_W-1:0]  col_i,
    input  logic              ap_i,
    output logic [ADDR_W-1:0] addr_o
);

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        if (i == AP_BIT) begin : g_ap
            assign addr_o[i] = ap_i;
        end else if (i < COL_W) begin : g_col
            assign addr_o[i] = col_i[i];
        end else begin : g_zero
            assign addr_o[i] = 1'b0;
        end
    end

endmodule

// File: rtl/sdwr_term_seq.sv
module sdwr_term_seq
    import sdwr_pkg::*;
#(
    parameter int BANK_W   = 2,
    parameter int COL_W    = 10,
    parameter int ADDR_W   = 13,
    parameter int AP_BIT   = 10,
    parameter int DATA_W   = 16,
    parameter int FIX_LEN  = 8,
    parameter int FAST_CLK = 1,
    parameter int RP_CYC   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [BANK_W-1:0]   req_bank,
    input  logic [COL_W-1:0]    req_col,
    input  logic [1:0]          req_kind,
    input  logic [COL_W:0]      req_stop,
    input  logic                req_pre,
    input  logic                req_all,
    input  logic [COL_W-1:0]    req_rcol,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                dat_take,
    output logic [3:0]          sd_cmd,
    output logic [BANK_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0]   sd_addr,
    output logic                sd_dqm,
    output logic [DATA_W-1:0]   dq_out,
    output logic                dq_oe
);

    localparam int CNT_W  = COL_W + 1;
    localparam int WR_CYC = (FAST_CLK != 0) ? 2 : 1;
    localparam int TMR_W  = $clog2(RP_CYC + 2);

    typedef struct packed {
        seq_st_e            st;
        logic [CNT_W-1:0]   left;
        logic [TMR_W-1:0]   tmr;
        logic               pre;
        logic               all;
        logic               trunc;
        logic [BANK_W-1:0]  bank;
        logic [COL_W-1:0]   rcol;
        sd_cmd_e            cmd;
        logic [BANK_W-1:0]  ba;
        logic [ADDR_W-1:0]  addr;
        logic               dqm;
        logic [DATA_W-1:0]  dq;
        logic               oe;
        logic               rdy;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic [CNT_W-1:0]  beats;
    logic              trunc;
    logic [ADDR_W-1:0] wr_addr, rd_addr, pre_addr;
    logic              take_d;

    sdwr_beat_calc #(.COL_W(COL_W), .FIX_LEN(FIX_LEN), .CNT_W(CNT_W)) u_len (
        .kind_i (req_kind),
        .stop_i (req_stop),
        .beats_o(beats),
        .trunc_o(trunc)
    );

    sdwr_addr_fmt #(.COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_wr_addr (
        .col_i (req_col),
        .ap_i  (1'b0),
        .addr_o(wr_addr)
    );

    sdwr_addr_fmt #(.COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_rd_addr (
        .col_i (r_q.rcol),
        .ap_i  (1'b0),
        .addr_o(rd_addr)
    );

    sdwr_addr_fmt #(.COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_pre_addr (
        .col_i ('0),
        .ap_i  (r_q.all),
        .addr_o(pre_addr)
    );

    always_comb begin
        r_d      = r_q;
        r_d.cmd  = CMD_NOP;
        r_d.ba   = '0;
        r_d.addr = '0;
        r_d.dqm  = 1'b0;
        r_d.dq   = '0;
        r_d.oe   = 1'b0;
        r_d.rdy  = 1'b0;
        take_d   = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid && r_q.rdy) begin
                    take_d     = 1'b1;
                    r_d.st     = ST_DATA;
                    r_d.left   = beats - 1'b1;
                    r_d.pre    = req_pre;
                    r_d.all    = req_all;
                    r_d.trunc  = trunc;
                    r_d.bank   = req_bank;
                    r_d.rcol   = req_rcol;
                    r_d.cmd    = CMD_WR;
                    r_d.ba     = req_bank;
                    r_d.addr   = wr_addr;
                    r_d.dq     = wr_data;
                    r_d.oe     = 1'b1;
                end else begin
                    r_d.rdy = 1'b1;
                end
            end
            ST_DATA: begin
                if (r_q.left != '0) begin
                    take_d   = 1'b1;
                    r_d.left = r_q.left - 1'b1;
                    r_d.dq   = wr_data;
                    r_d.oe   = 1'b1;
                end else if (!r_q.pre) begin
                    r_d.st   = ST_IDLE;
                    r_d.cmd  = CMD_RD;
                    r_d.ba   = r_q.bank;
                    r_d.addr = rd_addr;
                end else if (WR_CYC == 1) begin
                    r_d.st   = ST_RP;
                    r_d.tmr  = TMR_W'(RP_CYC - 1);
                    r_d.cmd  = CMD_PRE;
                    r_d.ba   = r_q.bank;
                    r_d.addr = pre_addr;
                    r_d.dqm  = r_q.trunc;
                end else begin
                    r_d.st  = ST_WREC;
                    r_d.tmr = TMR_W'(WR_CYC - 2);
                    r_d.dqm = r_q.trunc;
                end
            end
            ST_WREC: begin
                r_d.dqm = r_q.trunc;
                if (r_q.tmr == '0) begin
                    r_d.st   = ST_RP;
                    r_d.tmr  = TMR_W'(RP_CYC - 1);
                    r_d.cmd  = CMD_PRE;
                    r_d.ba   = r_q.bank;
                    r_d.addr = pre_addr;
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            default: begin
                if (r_q.tmr == '0) begin
                    r_d.st  = ST_IDLE;
                    r_d.rdy = 1'b1;
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.cmd   <= CMD_NOP;
            r_q.rdy   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = r_q.rdy;
    assign dat_take  = take_d;
    assign sd_cmd    = r_q.cmd;
    assign sd_ba     = r_q.ba;
    assign sd_addr   = r_q.addr;
    assign sd_dqm    = r_q.dqm;
    assign dq_out    = r_q.dq;
    assign dq_oe     = r_q.oe;

    // R2
    write_no_autopre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_WR) |-> (!sd_addr[AP_BIT] && !req_ready));

    // R9
    write_only_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_WR) |-> $past(req_ready && req_valid));

    // R4
    read_ends_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_RD) |-> (!dq_oe ##1 (!dq_oe && sd_cmd != CMD_WR)));

    // R10
    mask_off_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dqm |-> !dq_oe);

    // R5
    pre_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_PRE) |-> (!dq_oe && !req_ready));

    if (WR_CYC > 1) begin : g_wr2_chk
        // R5
        pre_recovery_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sd_cmd == CMD_PRE) |-> !$past(dq_oe));
    end

    if (RP_CYC > 1) begin : g_rp_chk
        // R8
        rp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sd_cmd == CMD_PRE) |=> (sd_cmd == CMD_NOP && !req_ready));
    end

endmodule

// File: tb/sdwr_term_seq_test.sv
module sdwr_term_seq_test;

    localparam int CLK_NS  = 10;
    localparam int BANK_W  = 2;
    localparam int COL_W   = 4;
    localparam int ADDR_W  = 13;
    localparam int AP_BIT  = 10;
    localparam int DATA_W  = 16;
    localparam int FIX_LEN = 4;
    localparam int RP_CYC  = 3;
    localparam int WR_CYC  = 2;
    localparam int PAGE    = 1 << COL_W;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_PRE = 4'b0010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [BANK_W-1:0] req_bank = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic [1:0]        req_kind = '0;
    logic [COL_W:0]    req_stop = '0;
    logic              req_pre = 1'b0;
    logic              req_all = 1'b0;
    logic [COL_W-1:0]  req_rcol = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              dat_take;
    logic [3:0]        sd_cmd;
    logic [BANK_W-1:0] sd_ba;
    logic [ADDR_W-1:0] sd_addr;
    logic              sd_dqm;
    logic [DATA_W-1:0] dq_out;
    logic              dq_oe;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;

    sdwr_term_seq #(
        .BANK_W(BANK_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT),
        .DATA_W(DATA_W), .FIX_LEN(FIX_LEN), .FAST_CLK(1), .RP_CYC(RP_CYC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_col(req_col), .req_kind(req_kind),
        .req_stop(req_stop), .req_pre(req_pre), .req_all(req_all),
        .req_rcol(req_rcol), .wr_data(wr_data), .dat_take(dat_take),
        .sd_cmd(sd_cmd), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #(CLK_NS / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DATA_W-1:0] pat(int c);
        return DATA_W'(16'h5A00 ^ c[15:0]);
    endfunction

    always @(negedge clk) wr_data = pat(cyc);

    function automatic logic [63:0] pack(logic [3:0] c, logic m, logic oe, logic tk,
                                         logic rd, logic [DATA_W-1:0] d,
                                         logic [ADDR_W-1:0] a, logic [BANK_W-1:0] b);
        return {25'b0, c, m, oe, tk, rd, d, a, b};
    endfunction

    task automatic cmp(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [63:0] observed();
        return pack(sd_cmd, sd_dqm, dq_oe, dat_take, req_ready, dq_out, sd_addr, sd_ba);
    endfunction

    task automatic check_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs while held in reset
        cmp("R1 in reset", observed(), pack(C_NOP, 0, 0, 0, 1, '0, '0, '0));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: idle after release
        cmp("R1 after release", observed(), pack(C_NOP, 0, 0, 0, 1, '0, '0, '0));
    endtask

    task automatic run_write(string name, logic [1:0] kind, int stop, bit pre, bit all,
                             int col, int rcol, int bank);
        int natural_len;
        int n;
        bit trunc;
        int w;
        int p;
        bit done;
        natural_len = (kind == 2'b00) ? 2 : (kind == 2'b01) ? FIX_LEN : PAGE;
        n     = (stop != 0 && stop < natural_len) ? stop : natural_len;
        trunc = (n < natural_len);
        p     = n - 1 + WR_CYC;
        w     = 0;
        done  = 1'b0;

        @(negedge clk);
        req_kind  = kind;
        req_stop  = (COL_W + 1)'(stop);
        req_pre   = pre;
        req_all   = all;
        req_col   = COL_W'(col);
        req_rcol  = COL_W'(rcol);
        req_bank  = BANK_W'(bank);
        req_valid = 1'b1;
        #1;
        // R2 and R3: accepted with first word taken
        cmp({name, " R2 accept"}, {62'b0, req_ready, dat_take}, {62'b0, 2'b11});

        for (int j = 0; j < 200 && !done; j++) begin
            logic [3:0]        e_cmd;
            logic              e_dqm, e_oe, e_take, e_rdy;
            logic [DATA_W-1:0] e_dq;
            logic [ADDR_W-1:0] e_addr;
            logic [BANK_W-1:0] e_ba;
            string             tag;
            @(negedge clk);
            if (j == 0) w = cyc;
            e_cmd = C_NOP; e_dqm = 0; e_oe = 0; e_take = 0; e_rdy = 0;
            e_dq = '0; e_addr = '0; e_ba = '0;
            if (j < n) begin
                e_oe   = 1;
                e_dq   = pat(w + j - 1);
                e_take = (j < n - 1);
                if (j == 0) begin
                    e_cmd = C_WR; e_addr = ADDR_W'(col); e_ba = BANK_W'(bank);
                    tag = "R2 write";
                end else begin
                    tag = "R3 R10 beat";
                end
            end else if (!pre) begin
                if (j == n) begin
                    e_cmd = C_RD; e_addr = ADDR_W'(rcol); e_ba = BANK_W'(bank);
                    tag = "R4 R10 read";
                end else begin
                    e_rdy = 1; e_take = 1; done = 1'b1;
                    tag = "R4 R9 ready";
                end
            end else begin
                if (j < p) begin
                    e_dqm = trunc;
                    tag = trunc ? "R6 R9 recovery" : "R5 R7 recovery";
                end else if (j == p) begin
                    e_cmd = C_PRE; e_dqm = trunc; e_ba = BANK_W'(bank);
                    e_addr = all ? ADDR_W'(1 << AP_BIT) : '0;
                    tag = trunc ? "R5 R6 precharge" : "R5 R7 precharge";
                end else if (j < p + RP_CYC) begin
                    tag = "R8 R9 gap";
                end else begin
                    e_rdy = 1; e_take = 1; done = 1'b1;
                    tag = "R8 ready";
                end
            end
            cmp({name, " ", tag}, observed(),
                pack(e_cmd, e_dqm, e_oe, e_take, e_rdy, e_dq, e_addr, e_ba));
            // R9: fields altered while busy, valid held high
            req_col  = ~COL_W'(col);
            req_rcol = ~COL_W'(rcol);
            req_pre  = ~pre;
            req_kind = ~kind;
            if (done) req_valid = 1'b0;
        end
        if (!done) begin
            n_bad++;
            $display("FAIL %s R8 sequence never returned ready actual=0 expected=1", name);
        end
    endtask

    initial begin
        #(CLK_NS * 20000);
        n_bad++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        check_reset();
        run_write("two_read",      2'b00, 0, 0, 0, 3,  9,  1);
        run_write("fix_pre",       2'b01, 0, 1, 0, 5,  0,  2);
        run_write("fix_cut_all",   2'b01, 3, 1, 1, 7,  0,  3);
        run_write("page_cut_read", 2'b10, 5, 0, 0, 12, 2,  0);
        run_write("page_full_pre", 2'b10, 0, 1, 0, 0,  0,  1);
        run_write("two_cut_pre",   2'b00, 1, 1, 0, 6,  0,  2);
        run_write("two_full_pre",  2'b00, 0, 1, 1, 8,  0,  0);
        run_write("fix_longstop",  2'b01, 9, 0, 0, 1,  14, 3);
        run_write("kind3_read",    2'b11, 0, 0, 0, 15, 4,  2);
        repeat (2) @(negedge clk);
        // R1: back at rest
        cmp("R1 rest", observed(), pack(C_NOP, 0, 0, 0, 1, '0, '0, '0));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule